// File: doc/BRIEF.md
# Block Erase Command Controller

This controller sits behind a serial-peripheral slave front end and turns a received bit stream into qualified block erase requests. Each frame opens when chip select falls. The first byte is an opcode and the next three bytes are a 24-bit address, both shifted in MSB first, one bit per strobe. Three opcodes name three block sizes. Every other opcode belongs to another command and is left alone.

Nothing happens while bits are still arriving. When chip select rises, the controller judges the frame as a whole. The write enable latch must be set, the address must be complete, the frame must end on a byte boundary, and the 64 KB sector that holds the address must not be protected. If every check holds, the controller announces the block base and size with a one-cycle go pulse. It then holds busy for a programmable number of clock cycles, which stands in for the erase time. If any check fails, no erase starts, and the latch is cleared in either case.

An erase failure reported while busy sets a sticky error bit. The next erase that launches clears it.

Top module: `blk_erase_ctrl`

## Requirements
- R1: Opcode 20h selects a 4 KB block (blk_size code 0), 52h selects 32 KB (code 1) and D8h selects 64 KB (code 2). A frame with any other opcode, or one that ends before its opcode byte is complete, launches nothing and leaves WEL unchanged.
- R2: On launch, blk_base equals the received address with bits 11..0 (4 KB), 14..0 (32 KB) or 15..0 (64 KB) cleared.
- R3: An erase is judged only at the rising edge of cs_n. On launch, erase_go is high for exactly one cycle and busy is set, both in the cycle after the clock edge that first samples cs_n high.
- R4: An erase opcode frame that ends while WEL is 0 launches nothing.
- R5: A frame that ends before all three address bytes are complete launches nothing.
- R6: A frame whose bit count is not a multiple of eight launches nothing.
- R7: Whole bytes received after the third address byte are ignored, and the erase launches with the address from the first three.
- R8: If bit addr[23:16] of prot_map is set, nothing launches. Protection of any other sector has no effect.
- R9: wel_set sets WEL. Every erase opcode frame that ends while the controller is idle clears WEL, whether it launches or aborts.
- R10: busy stays high for exactly erase_len cycles, and an erase_len of 0 counts as 1. The status layout is: bit 0 busy, bit 1 WEL, bit 5 erase error, all other bits 0.
- R11: A frame that ends while busy launches nothing and does not change WEL.
- R12: erase_fail sets the error bit only while busy, and it is ignored while idle. The bit stays set until the next launch clears it.
- R13: After reset the status is 00h and erase_go is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| bit_vld | input | 1 | One received serial bit is present this cycle |
| bit_dat | input | 1 | Value of the received bit, MSB first |
| wel_set | input | 1 | Sets the write enable latch |
| erase_fail | input | 1 | The array reports a failed erase |
| erase_len | input | 16 | Erase duration in clock cycles |
| prot_map | input | 256 | One protection bit per 64 KB sector |
| status | output | 8 | Status byte (busy, WEL, error) |
| erase_go | output | 1 | One-cycle launch pulse |
| blk_base | output | 24 | Base address of the block to erase |
| blk_size | output | 2 | Block size code |

## Verification
The hardest case to reach is a valid erase frame that ends while an earlier erase is still running. To produce it, the bench starts an erase with a long erase_len, sets WEL again while busy, and streams a second complete frame. It then checks that no go pulse appears and that WEL survives. The byte-alignment and incomplete-address aborts both need frames cut off at exact bit counts, and the vector table supplies them alongside the normal frames. A protection bit on a neighbouring sector is kept on in the normal cases, so that only a match on the addressed sector blocks the erase.

// File: rtl/blk_erase_pkg.sv
package blk_erase_pkg;

  typedef enum logic [1:0] {
    SZ_4K  = 2'd0,
    SZ_32K = 2'd1,
    SZ_64K = 2'd2
  } blk_size_e;

  localparam logic [7:0] OPC_ERASE_4K  = 8'h20;
  localparam logic [7:0] OPC_ERASE_32K = 8'h52;
  localparam logic [7:0] OPC_ERASE_64K = 8'hD8;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_EPE  = 5;

  function automatic logic op_is_erase(input logic [7:0] op);
    return (op == OPC_ERASE_4K) || (op == OPC_ERASE_32K) || (op == OPC_ERASE_64K);
  endfunction

  function automatic blk_size_e op_size(input logic [7:0] op);
    case (op)
      OPC_ERASE_32K: return SZ_32K;
      OPC_ERASE_64K: return SZ_64K;
      default:       return SZ_4K;
    endcase
  endfunction

  // number of low address bits that do not select the block
  function automatic int unsigned size_shift(input blk_size_e s);
    case (s)
      SZ_32K:  return 15;
      SZ_64K:  return 16;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/blk_erase_rx.sv
module blk_erase_rx #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_vld,
  input  logic              bit_dat,
  output logic              cs_rise,
  output logic              op_seen,
  output logic              addr_full,
  output logic              aligned,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addr
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_BYTES);

  logic             cs_q;
  logic [7:0]       shreg;
  logic [2:0]       bit_phase;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       sh_nxt;
  logic             byte_done;

  assign sh_nxt    = {shreg[6:0], bit_dat};
  assign byte_done = bit_vld && !cs_n && (bit_phase == 3'd7);

  assign cs_rise   = cs_n && !cs_q;
  assign op_seen   = (byte_cnt != '0);
  assign addr_full = (byte_cnt == CNT_SAT);
  assign aligned   = (bit_phase == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q      <= 1'b1;
      shreg     <= '0;
      bit_phase <= '0;
      byte_cnt  <= '0;
      opcode    <= '0;
      addr      <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        bit_phase <= '0;
        byte_cnt  <= '0;
      end else if (bit_vld) begin
        shreg     <= sh_nxt;
        bit_phase <= bit_phase + 3'd1;
        if (byte_done) begin
          if (byte_cnt == '0)
            opcode <= sh_nxt;
          else if (byte_cnt <= CNT_ADDR)
            addr <= {addr[ADDR_W-9:0], sh_nxt};
          if (byte_cnt != CNT_SAT)
            byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blk_erase_qual.sv
module blk_erase_qual
  import blk_erase_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 8
) (
  input  logic                 cs_rise,
  input  logic                 busy,
  input  logic                 wel,
  input  logic                 op_seen,
  input  logic                 addr_full,
  input  logic                 aligned,
  input  logic [7:0]           opcode,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  output logic                 cmd_end,
  output logic                 launch,
  output logic                 abort,
  output blk_size_e            size,
  output logic [ADDR_W-1:0]    base
);
  logic [SECT_W-1:0] sector;
  logic              locked;
  logic              all_ok;

  assign sector  = addr[ADDR_W-1 -: SECT_W];
  assign locked  = prot_map[sector];
  assign all_ok  = wel && addr_full && aligned && !locked;

  assign cmd_end = cs_rise && !busy && op_seen && op_is_erase(opcode);
  assign launch  = cmd_end && all_ok;
  assign abort   = cmd_end && !all_ok;

  assign size = op_size(opcode);
  assign base = (addr >> size_shift(size)) << size_shift(size);

endmodule

// File: rtl/blk_erase_timer.sv
module blk_erase_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] cnt;

  assign done = busy && (cnt == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (len == '0) ? LEN_W'(1) : len;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/blk_erase_ctrl.sv
module blk_erase_ctrl
  import blk_erase_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SECT_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   bit_vld,
  input  logic                   bit_dat,
  input  logic                   wel_set,
  input  logic                   erase_fail,
  input  logic [LEN_W-1:0]       erase_len,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  output logic [7:0]             status,
  output logic                   erase_go,
  output logic [ADDR_W-1:0]      blk_base,
  output logic [1:0]             blk_size
);
  logic              cs_rise, op_seen, addr_full, aligned;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr;
  logic              cmd_end, launch, abort;
  blk_size_e         q_size;
  logic [ADDR_W-1:0] q_base;
  logic              busy, done;
  logic              wel_q, epe_q, go_q;
  blk_size_e         size_q;
  logic [ADDR_W-1:0] base_q;

  blk_erase_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .cs_rise(cs_rise), .op_seen(op_seen), .addr_full(addr_full), .aligned(aligned),
    .opcode(opcode), .addr(addr)
  );

  blk_erase_qual #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_qual (
    .cs_rise(cs_rise), .busy(busy), .wel(wel_q), .op_seen(op_seen),
    .addr_full(addr_full), .aligned(aligned), .opcode(opcode), .addr(addr),
    .prot_map(prot_map), .cmd_end(cmd_end), .launch(launch), .abort(abort),
    .size(q_size), .base(q_base)
  );

  blk_erase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .len(erase_len),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      epe_q  <= 1'b0;
      go_q   <= 1'b0;
      size_q <= SZ_4K;
      base_q <= '0;
    end else begin
      go_q <= launch;
      if (cmd_end)      wel_q <= 1'b0;
      else if (wel_set) wel_q <= 1'b1;
      if (launch)                  epe_q <= 1'b0;
      else if (busy && erase_fail) epe_q <= 1'b1;
      if (launch) begin
        size_q <= q_size;
        base_q <= q_base;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEL]  = wel_q;
    status[ST_EPE]  = epe_q;
  end

  assign erase_go = go_q;
  assign blk_base = base_q;
  assign blk_size = size_q;

endmodule

// File: rtl/blk_erase_chk.sv
module blk_erase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_rise,
  input logic        launch,
  input logic        abort,
  input logic        cmd_end,
  input logic        done,
  input logic        busy,
  input logic        wel,
  input logic        epe,
  input logic        erase_go,
  input logic        erase_fail,
  input logic [1:0]  blk_size,
  input logic [15:0] base_lo
);
  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && erase_go));
  // R3
  go_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> $past(cs_rise));
  // R11
  idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
  // R9
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> !wel);
  // R5
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !erase_go);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R12
  epe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(epe) |-> $past(busy && erase_fail));
  // R2
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_go && blk_size == 2'd2) |-> (base_lo == 16'h0000));
endmodule

bind blk_erase_ctrl blk_erase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .launch(launch), .abort(abort),
  .cmd_end(cmd_end), .done(done), .busy(busy), .wel(wel_q), .epe(epe_q),
  .erase_go(erase_go), .erase_fail(erase_fail), .blk_size(blk_size),
  .base_lo(blk_base[15:0])
);

// File: tb/test_blk_erase_ctrl.sv
module test_blk_erase_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         bit_vld = 1'b0;
  logic         bit_dat = 1'b0;
  logic         wel_set = 1'b0;
  logic         erase_fail = 1'b0;
  logic [15:0]  erase_len = 16'd5;
  logic [255:0] prot_map = '0;
  logic [7:0]   status;
  logic         erase_go;
  logic [23:0]  blk_base;
  logic [1:0]   blk_size;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  blk_erase_ctrl i_blk_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .wel_set(wel_set), .erase_fail(erase_fail), .erase_len(erase_len),
    .prot_map(prot_map), .status(status), .erase_go(erase_go),
    .blk_base(blk_base), .blk_size(blk_size)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  nbits;
    logic        wel;
    logic        prot;
    logic        go;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{8'h20, 24'h123456, 8'd32, 1'b1, 1'b0, 1'b1},
    '{8'h52, 24'h12FFFF, 8'd32, 1'b1, 1'b0, 1'b1},
    '{8'hD8, 24'hABCDEF, 8'd40, 1'b1, 1'b0, 1'b1},
    '{8'h20, 24'h654321, 8'd32, 1'b0, 1'b0, 1'b0},
    '{8'h20, 24'h654321, 8'd24, 1'b1, 1'b0, 1'b0},
    '{8'h52, 24'h0F0F0F, 8'd35, 1'b1, 1'b0, 1'b0},
    '{8'hD8, 24'hA51234, 8'd32, 1'b1, 1'b1, 1'b0},
    '{8'h03, 24'h000100, 8'd32, 1'b1, 1'b0, 1'b0},
    '{8'hD8, 24'hFFFFFF, 8'd32, 1'b1, 1'b0, 1'b1},
    '{8'h20, 24'h000FFF, 8'd20, 1'b1, 1'b0, 1'b0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R1 R2 R3 4K";
      1: return "R1 R2 32K";
      2: return "R7 64K trailing byte";
      3: return "R4 no WEL";
      4: return "R5 short address";
      5: return "R6 unaligned end";
      6: return "R8 protected sector";
      7: return "R1 R9 other opcode";
      8: return "R2 64K top";
      default: return "R5 R6 short and unaligned";
    endcase
  endfunction

  function automatic logic is_erase_op(input logic [7:0] op);
    return op == 8'h20 || op == 8'h52 || op == 8'hD8;
  endfunction

  function automatic logic [23:0] exp_base(input logic [7:0] op, input logic [23:0] a);
    case (op)
      8'h20:   return {a[23:12], 12'h000};
      8'h52:   return {a[23:15], 15'h0000};
      default: return {a[23:16], 16'h0000};
    endcase
  endfunction

  function automatic logic [1:0] exp_size(input logic [7:0] op);
    return (op == 8'h20) ? 2'd0 : (op == 8'h52) ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [23:0] a, input int nbits);
    logic [63:0] v;
    v = {op, a, 32'hD85220FF};
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      bit_vld = 1'b1;
      bit_dat = v[63-i];
      @(negedge clk);
    end
    bit_vld = 1'b0;
    cs_n    = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_wel();
    @(negedge clk);
    wel_set = 1'b1;
    @(negedge clk);
    wel_set = 1'b0;
  endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 status after reset", 32'(status), 32'h00);
    chk("R13 erase_go after reset", 32'(erase_go), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 10; i++) begin
      wait_idle();
      prot_map = '0;
      if (VEC[i].prot) prot_map[VEC[i].addr[23:16]] = 1'b1;
      else             prot_map[8'(VEC[i].addr[23:16] + 8'd1)] = 1'b1;
      if (VEC[i].wel) pulse_wel();
      send_frame(VEC[i].op, VEC[i].addr, int'(VEC[i].nbits));
      chk({vec_tag(i), " erase_go"}, 32'(erase_go), 32'(VEC[i].go));
      chk({vec_tag(i), " busy"}, 32'(status[0]), 32'(VEC[i].go));
      chk({vec_tag(i), " R9 WEL after"}, 32'(status[1]),
          is_erase_op(VEC[i].op) ? 32'h0 : 32'(VEC[i].wel));
      if (VEC[i].go) begin
        chk({vec_tag(i), " base"}, 32'(blk_base), 32'(exp_base(VEC[i].op, VEC[i].addr)));
        chk({vec_tag(i), " size"}, 32'(blk_size), 32'(exp_size(VEC[i].op)));
        @(negedge clk);
        chk({vec_tag(i), " R3 go is one pulse"}, 32'(erase_go), 32'h0);
      end
    end
    wait_idle();
    prot_map = '0;

    // R10 busy lasts erase_len cycles
    erase_len = 16'd3;
    pulse_wel();
    send_frame(8'h20, 24'h001000, 32);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
    chk("R10 busy cycles len=3", 32'(n), 32'd3);

    erase_len = 16'd0;
    pulse_wel();
    send_frame(8'h52, 24'h008000, 32);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
    chk("R10 busy cycles len=0", 32'(n), 32'd1);

    // R12 fail while idle ignored
    erase_fail = 1'b1;
    @(negedge clk);
    erase_fail = 1'b0;
    chk("R12 idle fail ignored", 32'(status[5]), 32'h0);

    // R11 command while busy ignored
    erase_len = 16'd80;
    pulse_wel();
    send_frame(8'hD8, 24'h020000, 32);
    chk("R11 first launch", 32'(erase_go), 32'h1);
    pulse_wel();
    send_frame(8'h20, 24'h030000, 32);
    chk("R11 busy frame no go", 32'(erase_go), 32'h0);
    chk("R11 WEL kept", 32'(status[1]), 32'h1);
    chk("R11 still busy", 32'(status[0]), 32'h1);
    // R12 fail while busy
    erase_fail = 1'b1;
    @(negedge clk);
    erase_fail = 1'b0;
    wait_idle();
    chk("R12 R10 status after failed erase", 32'(status), 32'h22);

    // R12 next launch clears error
    erase_len = 16'd4;
    send_frame(8'h20, 24'h040000, 32);
    chk("R12 launch clears error", 32'(status), 32'h01);
    wait_idle();

    // R1 frame ends before opcode complete: WEL unchanged
    pulse_wel();
    send_frame(8'h20, 24'h000000, 5);
    chk("R1 partial opcode WEL kept", 32'(status), 32'h02);
    chk("R1 partial opcode no go", 32'(erase_go), 32'h0);

    finish_run();
  end
endmodule